// File: doc/BRIEF.md
# Conditional-zero execute unit

This unit sits in the execute stage of an integer pipeline and handles exactly two register-register operations. Both pass the first source value to the destination or replace it with zero. The choice depends on whether the second source value is zero. One operation zeroes the result when the condition operand is zero. The other zeroes it when the condition operand is nonzero. A compiler pairs these with an add, or, xor or similar instruction to build branchless conditional arithmetic and conditional selects.

Each cycle the unit takes a valid strobe, a 32-bit instruction word and two source values of XLEN bits. It checks the word against the exact encoding of the two operations. One register stage later it presents the result, the destination index and a write-enable. If the word is not one of its two operations, it raises a not-mine flag instead. The condition is tested by OR-reducing the whole second operand. The result is formed by masking, so the latency is one cycle for every operand value.

Top module: `czu_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wen_o`, `foreign_o`, `res_o` and `rd_o` are all zero.
- R2: A valid word matches when bits [6:0] are 0x33, bits [31:25] are 0x07 and bits [14:12] are 5 or 7. One cycle after a matched word with a nonzero destination, `wen_o` is 1, `foreign_o` is 0 and `rd_o` equals bits [11:7].
- R3: For a matched word with bits [14:12] = 5, `res_o` one cycle later is zero when `src_b_i` is zero and equals `src_a_i` otherwise.
- R4: For a matched word with bits [14:12] = 7, `res_o` one cycle later is zero when `src_b_i` is nonzero and equals `src_a_i` otherwise.
- R5: The condition uses every bit of `src_b_i`. A `src_b_i` with a single set bit at any position, the top bit included, counts as nonzero.
- R6: A valid word that differs from a match in any opcode, funct3 or funct7 bit gives `foreign_o` = 1, `wen_o` = 0, `res_o` = 0 and `rd_o` = 0 one cycle later. Changing only bits [11:7], [19:15] or [24:20] never makes a word foreign.
- R7: A matched word with bits [11:7] = 0 gives `wen_o` = 0 and `foreign_o` = 0. The computed result still appears on `res_o`.
- R8: A cycle with `in_valid_i` low gives `wen_o`, `foreign_o`, `res_o` and `rd_o` all zero on the next cycle, whatever the word and operands are.
- R9: The latency is exactly one cycle for every input. Inputs applied on consecutive cycles produce outputs on consecutive cycles, and each output depends only on the input one cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The instruction word and operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | Value operand |
| src_b_i | input | XLEN | Condition operand |
| res_o | output | XLEN | Registered result |
| rd_o | output | 5 | Registered destination index |
| wen_o | output | 1 | Register-file write-enable |
| foreign_o | output | 1 | The word was valid but is not one of the two operations |

## Verification
The registered output of one word and the decode of the next word fall in the same cycle. The bench therefore drives a stream with a new word on every cycle, mixing matched, foreign, idle and destination-zero words. It checks each output against a model of the word applied exactly one cycle earlier. A second overlap is the destination-zero suppression and a normal computed result in the same retiring word. Those vectors check that `res_o` carries the data while `wen_o` stays low.

// File: rtl/czu_pkg.sv
package czu_pkg;

    localparam logic [6:0] OPC_REGREG  = 7'h33;
    localparam logic [6:0] F7_CZERO    = 7'h07;
    localparam logic [2:0] F3_ON_EQZ   = 3'h5;
    localparam logic [2:0] F3_ON_NEZ   = 3'h7;

    typedef struct packed {
        logic [6:0] f7;
        logic [4:0] cond_idx;
        logic [4:0] val_idx;
        logic [2:0] f3;
        logic [4:0] dst;
        logic [6:0] opc;
    } insn_fields_t;

    typedef enum logic [1:0] {
        CZ_NONE     = 2'd0,
        CZ_ZERO_EQZ = 2'd1,
        CZ_ZERO_NEZ = 2'd2
    } cz_op_e;

endpackage

// File: rtl/czu_decode.sv
module czu_decode
    import czu_pkg::*;
(
    input  logic [31:0] insn_i,
    output cz_op_e      op_o,
    output logic [4:0]  dst_o
);

    insn_fields_t fld;
    logic         major_hit;

    assign fld       = insn_fields_t'(insn_i);
    assign major_hit = (fld.opc == OPC_REGREG) && (fld.f7 == F7_CZERO);
    assign dst_o     = fld.dst;

    always_comb begin
        op_o = CZ_NONE;
        if (major_hit) begin
            case (fld.f3)
                F3_ON_EQZ: op_o = CZ_ZERO_EQZ;
                F3_ON_NEZ: op_o = CZ_ZERO_NEZ;
                default:   op_o = CZ_NONE;
            endcase
        end
    end

endmodule

// File: rtl/czu_select.sv
module czu_select
    import czu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cz_op_e            op_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    output logic [XLEN-1:0]   res_o
);

    logic            cond_nz;
    logic            keep;
    logic [XLEN-1:0] keep_mask;

    // Full-width reduction: every bit of the condition takes part.
    assign cond_nz = |src_b_i;

    always_comb begin
        unique case (op_i)
            CZ_ZERO_EQZ: keep = cond_nz;
            CZ_ZERO_NEZ: keep = ~cond_nz;
            default:     keep = 1'b0;
        endcase
    end

    // Mask instead of a data-dependent path, so timing does not vary.
    assign keep_mask = {XLEN{keep}};
    assign res_o     = src_a_i & keep_mask;

endmodule

// File: rtl/czu_top.sv
module czu_top
    import czu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            in_valid_i,
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    output logic [XLEN-1:0] res_o,
    output logic [4:0]      rd_o,
    output logic            wen_o,
    output logic            foreign_o
);

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic [4:0]      rd;
        logic            wen;
        logic            foreign;
    } out_t;

    cz_op_e          dec_op;
    logic [4:0]      dec_dst;
    logic [XLEN-1:0] sel_res;
    logic            hit;
    out_t            out_d, out_q;

    czu_decode u_decode (
        .insn_i (insn_i),
        .op_o   (dec_op),
        .dst_o  (dec_dst)
    );

    czu_select #(.XLEN(XLEN)) u_select (
        .op_i    (dec_op),
        .src_a_i (src_a_i),
        .src_b_i (src_b_i),
        .res_o   (sel_res)
    );

    assign hit = in_valid_i && (dec_op != CZ_NONE);

    always_comb begin
        out_d         = '0;
        out_d.foreign = in_valid_i && !hit;
        if (hit) begin
            out_d.res = sel_res;
            out_d.rd  = dec_dst;
            out_d.wen = (dec_dst != 5'd0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o     = out_q.res;
    assign rd_o      = out_q.rd;
    assign wen_o     = out_q.wen;
    assign foreign_o = out_q.foreign;

    AST_WEN_FOREIGN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wen_o && foreign_o)); // R6

    AST_BAD_OPCODE_FOREIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && insn_i[6:0] != 7'h33) |=> (foreign_o && !wen_o && res_o == '0)); // R6

    AST_EQZ_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && insn_i[6:0] == 7'h33 && insn_i[31:25] == 7'h07
         && insn_i[14:12] == 3'h5 && src_b_i == '0) |=> (res_o == '0)); // R3

    AST_NEZ_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && insn_i[6:0] == 7'h33 && insn_i[31:25] == 7'h07
         && insn_i[14:12] == 3'h7 && src_b_i != '0) |=> (res_o == '0)); // R4

    AST_ONEHOT_COND_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && insn_i[6:0] == 7'h33 && insn_i[31:25] == 7'h07
         && insn_i[14:12] == 3'h5 && $countones(src_b_i) == 1) |=> (res_o == $past(src_a_i))); // R5

    AST_X0_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen_o |-> (rd_o != 5'd0)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> (!wen_o && !foreign_o && res_o == '0)); // R8

endmodule

// File: tb/tb_czu_top.sv
module tb_czu_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         vld;
    logic [31:0]  insn;
    logic [W-1:0] a, b;
    logic [W-1:0] res;
    logic [4:0]   rd;
    logic         wen, foreign;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    czu_top #(.XLEN(W)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .in_valid_i (vld),
        .insn_i     (insn),
        .src_a_i    (a),
        .src_b_i    (b),
        .res_o      (res),
        .rd_o       (rd),
        .wen_o      (wen),
        .foreign_o  (foreign)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [2:0] f3,
                                       input logic [4:0] rdx, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rdx, opc};
    endfunction

    task automatic compare(input string tag, input logic [W-1:0] er, input logic [4:0] erd,
                           input logic ew, input logic ef);
        n_vec++;
        if (res !== er || rd !== erd || wen !== ew || foreign !== ef) begin
            n_fail++;
            $display("FAIL %s: got res=%h rd=%0d wen=%b foreign=%b, expected res=%h rd=%0d wen=%b foreign=%b",
                     tag, res, rd, wen, foreign, er, erd, ew, ef);
        end
    endtask

    // Drive one cycle of inputs, then check the output one cycle later.
    task automatic step(input string tag, input logic v, input logic [31:0] w,
                        input logic [W-1:0] va, input logic [W-1:0] vb);
        logic          m;
        logic          keep;
        logic [W-1:0]  er;
        logic [4:0]    erd;
        vld = v; insn = w; a = va; b = vb;
        m    = v && w[6:0] == 7'h33 && w[31:25] == 7'h07 && (w[14:12] == 3'd5 || w[14:12] == 3'd7);
        keep = (w[14:12] == 3'd5) ? (vb != 0) : (vb == 0);
        er   = (m && keep) ? va : '0;
        erd  = m ? w[11:7] : 5'd0;
        @(negedge clk);
        compare(tag, er, erd, m && erd != 0, v && !m);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R9: watchdog expired, got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] alist [4];
        rst_n = 1'b0; vld = 1'b0; insn = '0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        compare("R1", '0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        vld = 1'b0;
        @(negedge clk);
        compare("R1", '0, 5'd0, 1'b0, 1'b0);

        // R3 / R4: operand sweeps for both operations
        for (int f = 0; f < 2; f++) begin
            for (int bv = 0; bv < 256; bv++) begin
                alist[0] = 8'h00; alist[1] = 8'hFF; alist[2] = 8'hA5; alist[3] = 8'(bv) ^ 8'h5A;
                for (int k = 0; k < 4; k++) begin
                    step(f == 0 ? "R3" : "R4", 1'b1,
                         mk(7'h07, 5'd2, 5'd1, f == 0 ? 3'd5 : 3'd7, 5'((bv % 31) + 1), 7'h33),
                         alist[k], 8'(bv));
                end
            end
        end

        // R5: single set bit at each position, including the top one
        for (int bit_i = 0; bit_i < W; bit_i++) begin
            step("R5", 1'b1, mk(7'h07, 5'd4, 5'd5, 3'd5, 5'd6, 7'h33), 8'hC3, 8'(1 << bit_i));
            step("R5", 1'b1, mk(7'h07, 5'd4, 5'd5, 3'd7, 5'd6, 7'h33), 8'hC3, 8'(1 << bit_i));
        end

        // R2 / R6: flip each bit of a matching word
        for (int bit_i = 0; bit_i < 32; bit_i++) begin
            logic [31:0] w;
            w = mk(7'h07, 5'd9, 5'd8, 3'd5, 5'd3, 7'h33) ^ (32'd1 << bit_i);
            if ((bit_i >= 7 && bit_i <= 11) || (bit_i >= 15 && bit_i <= 24) || bit_i == 13)
                step("R2", 1'b1, w, 8'h3C, 8'h01);
            else
                step("R6", 1'b1, w, 8'h3C, 8'h01);
        end
        for (int f = 0; f < 8; f++) begin
            step((f == 5 || f == 7) ? "R2" : "R6", 1'b1,
                 mk(7'h07, 5'd1, 5'd2, 3'(f), 5'd17, 7'h33), 8'h77, 8'h00);
        end
        step("R6", 1'b1, mk(7'h00, 5'd1, 5'd2, 3'd5, 5'd17, 7'h33), 8'h77, 8'h10);
        step("R6", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd7, 5'd17, 7'h13), 8'h77, 8'h00);

        // R7: destination zero keeps the result but not the write
        step("R7", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd5, 5'd0, 7'h33), 8'h9E, 8'h40);
        step("R7", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd7, 5'd0, 7'h33), 8'h9E, 8'h00);
        step("R7", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd7, 5'd0, 7'h33), 8'h9E, 8'h80);

        // R8: idle cycles ignore a matching word and operands
        for (int k = 0; k < 8; k++) begin
            step("R8", 1'b0, mk(7'h07, 5'd1, 5'd2, k[0] ? 3'd7 : 3'd5, 5'd12, 7'h33),
                 8'(k * 37 + 1), 8'(k));
        end

        // R9: mixed back-to-back stream
        for (int k = 0; k < 24; k++) begin
            case (k % 4)
                0: step("R9", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd5, 5'(k + 1), 7'h33), 8'(k + 100), 8'(k));
                1: step("R9", 1'b1, mk(7'h01, 5'd1, 5'd2, 3'd5, 5'd7, 7'h33), 8'hEE, 8'h01);
                2: step("R9", 1'b1, mk(7'h07, 5'd1, 5'd2, 3'd7, 5'(k), 7'h33), 8'(k * 3), 8'(k & 1));
                default: step("R9", 1'b0, '0, 8'hFF, 8'hFF);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule